// File: doc/BRIEF.md
# Bridge Power-State Gate

This block keeps the two-bit device power state of a bridge and decides, cycle by cycle, whether the bridge takes part in traffic. A small configuration port of dword address, byte enables and data reaches three dwords. The first is the power-management control dword, whose low two bits are the power state. The second is a read-only capability header for subsystem identification. The third is the status dword, which carries the received-master-abort flag.

Downstream cycle requests, interrupt requests and memory-mapped register accesses enter on their own inputs. The block answers each one registered, one clock later. In the full-power state everything passes. In the sleep state (D3) the bridge refuses every downstream cycle except type 0 configuration cycles, drops interrupts, and ignores memory-mapped accesses. Every refused downstream cycle sets the received-master-abort flag.

Top module: `bridge_pm_gate`

## Requirements
- R1: After reset the power state is D0 (encoding 00). The received-master-abort flag, `dn_claim`, `dn_abort`, `irq_out`, `mmr_ack`, `cfg_rd_valid` and `cfg_rdata` are all zero. A read of dword 21h (byte offset 84h) then returns 00000008h.
- R2: A write to dword 21h with `cfg_be[0]` set and data bits 1:0 equal to 00 (D0) or 11 (D3) stores that state. Dword 21h then reads 00000008h with the state in bits 1:0, so D3 reads 0000000Bh.
- R3: A write to dword 21h whose bits 1:0 carry 01 (D1) or 10 (D2) is accepted with no error, but the stored state does not change.
- R4: A write to dword 21h with `cfg_be[0]` clear leaves the power state unchanged. Bits 31:2 of dword 21h are read-only.
- R5: A state write changes the state at the clock edge that accepts it. A request presented in the same cycle is judged by the old state.
- R6: In D0 every downstream request is claimed: `dn_claim` is 1 and `dn_abort` is 0 one cycle after `dn_req`. `dn_type` encodes memory 00, I/O 01, configuration type 0 10 and configuration type 1 11. `dn_claim` and `dn_abort` are never high together.
- R7: In D3 a request with `dn_type` 10 (configuration type 0) is still claimed. Every other type is aborted: `dn_abort` is 1 one cycle later.
- R8: `irq_out` equals the `irq_in` of the previous cycle when the state was D0, and is 0 when the state was D3.
- R9: `mmr_ack` is 1 one cycle after `mmr_req` only if the state was D0.
- R10: The received-master-abort flag `rma_flag` is set on the same edge that drives `dn_abort` high. It reads as bit 29 of dword 01h (status bit 13). Writing 1 to that bit with `cfg_be[3]` set clears it. A new abort in the clearing cycle wins.
- R11: Dword 22h (byte offset 88h) reads 0000800Dh: ID 0Dh in bits 7:0, next pointer 80h in bits 15:8, zero above. Writes to it have no effect. Any dword not listed reads zero.
- R12: A read requested in one cycle returns `cfg_rdata` with `cfg_rd_valid` high on the next cycle, reflecting the state before any write made in the read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_rd_en | input | 1 | Configuration read strobe |
| cfg_addr | input | 6 | Dword address |
| cfg_be | input | 4 | Byte enables |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, registered |
| cfg_rd_valid | output | 1 | Read data valid |
| dn_req | input | 1 | Downstream cycle request |
| dn_type | input | 2 | Downstream cycle type |
| dn_claim | output | 1 | Request claimed |
| dn_abort | output | 1 | Request master-aborted |
| irq_in | input | 1 | Interrupt request from device logic |
| irq_out | output | 1 | Gated interrupt |
| mmr_req | input | 1 | Memory-mapped register access |
| mmr_ack | output | 1 | Access accepted |
| rma_flag | output | 1 | Received-master-abort status |

## Verification
The assertions assume a synchronous reset held for at least one clock. They assume every input settles well before a rising edge and stays defined (no X) outside reset. Downstream requests, reads and writes may overlap freely.

The bench changes inputs only on the falling edge and draws each field from a bounded range. It aims writes at the three mapped dwords most of the time, so writes of 01 and 10 and partial byte enables occur often, without leaving the defined encodings.

// File: rtl/bpg_pkg.sv
package bpg_pkg;
  typedef enum logic [1:0] {
    PS_D0 = 2'b00,
    PS_D1 = 2'b01,
    PS_D2 = 2'b10,
    PS_D3 = 2'b11
  } pstate_e;

  typedef enum logic [1:0] {
    CYC_MEM  = 2'b00,
    CYC_IO   = 2'b01,
    CYC_CFG0 = 2'b10,
    CYC_CFG1 = 2'b11
  } cyc_e;

  // Only the full-power and sleep states are implemented.
  function automatic logic ps_supported(input logic [1:0] v);
    return (v == PS_D0) || (v == PS_D3);
  endfunction
endpackage

// File: rtl/bpg_pm_reg.sv
module bpg_pm_reg
  import bpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr_stb,
  input  logic [1:0] wr_val,
  output logic [1:0] pm_state
);
  always_ff @(posedge clk) begin
    if (rst)         pm_state <= PS_D0;
    else if (wr_stb) pm_state <= wr_val;
  end
endmodule

// File: rtl/bpg_cfg_port.sv
module bpg_cfg_port
  import bpg_pkg::*;
#(
  parameter int          ADDR_W   = 6,
  parameter int          DATA_W   = 32,
  parameter logic [5:0]  PM_DW    = 6'h21,
  parameter logic [5:0]  CAP_DW   = 6'h22,
  parameter logic [5:0]  STS_DW   = 6'h01,
  parameter logic [7:0]  CAP_ID   = 8'h0D,
  parameter logic [7:0]  NEXT_PTR = 8'h80,
  parameter logic [31:0] PM_RO    = 32'h0000_0008,
  parameter int          RMA_BIT  = 29
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W/8-1:0] be,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        pm_state,
  input  logic              abort_evt,
  output logic              pm_wr_stb,
  output logic [1:0]        pm_wr_val,
  output logic              rma_flag,
  output logic [DATA_W-1:0] rdata,
  output logic              rd_valid
);
  localparam int NBYTES = DATA_W / 8;
  localparam logic [DATA_W-1:0] RMA_MASK = DATA_W'(1) << RMA_BIT;

  logic [DATA_W-1:0] bemask;
  logic [DATA_W-1:0] rd_mux;
  logic              clr_req;

  // Expand the byte enables into a bit mask.
  for (genvar g = 0; g < NBYTES; g++) begin : g_bemask
    assign bemask[8*g +: 8] = {8{be[g]}};
  end

  assign clr_req   = wr_en && (addr == ADDR_W'(STS_DW)) &&
                     (|(wdata & bemask & RMA_MASK));
  assign pm_wr_stb = wr_en && (addr == ADDR_W'(PM_DW)) && be[0] &&
                     ps_supported(wdata[1:0]);
  assign pm_wr_val = wdata[1:0];

  // Setting by a new abort takes precedence over clearing.
  always_ff @(posedge clk) begin
    if (rst)            rma_flag <= 1'b0;
    else if (abort_evt) rma_flag <= 1'b1;
    else if (clr_req)   rma_flag <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    if (addr == ADDR_W'(PM_DW))
      rd_mux = PM_RO | DATA_W'(pm_state);
    else if (addr == ADDR_W'(CAP_DW))
      rd_mux = DATA_W'({NEXT_PTR, CAP_ID});
    else if (addr == ADDR_W'(STS_DW))
      rd_mux = rma_flag ? RMA_MASK : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/bpg_gate.sv
module bpg_gate
  import bpg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] pm_state,
  input  logic       dn_req,
  input  logic [1:0] dn_type,
  input  logic       irq_in,
  input  logic       mmr_req,
  output logic       dn_claim,
  output logic       dn_abort,
  output logic       irq_out,
  output logic       mmr_ack,
  output logic       abort_evt
);
  logic in_d0;
  logic take;

  assign in_d0     = (pm_state == PS_D0);
  assign take      = dn_req && (in_d0 || (dn_type == CYC_CFG0));
  assign abort_evt = dn_req && !take;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_claim <= 1'b0;
      dn_abort <= 1'b0;
      irq_out  <= 1'b0;
      mmr_ack  <= 1'b0;
    end else begin
      dn_claim <= take;
      dn_abort <= abort_evt;
      irq_out  <= irq_in && in_d0;
      mmr_ack  <= mmr_req && in_d0;
    end
  end
endmodule

// File: rtl/bridge_pm_gate.sv
module bridge_pm_gate #(
  parameter int         ADDR_W = 6,
  parameter int         DATA_W = 32,
  parameter logic [5:0] PM_DW  = 6'h21,
  parameter logic [5:0] CAP_DW = 6'h22,
  parameter logic [5:0] STS_DW = 6'h01
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_wr_en,
  input  logic                cfg_rd_en,
  input  logic [ADDR_W-1:0]   cfg_addr,
  input  logic [DATA_W/8-1:0] cfg_be,
  input  logic [DATA_W-1:0]   cfg_wdata,
  output logic [DATA_W-1:0]   cfg_rdata,
  output logic                cfg_rd_valid,
  input  logic                dn_req,
  input  logic [1:0]          dn_type,
  output logic                dn_claim,
  output logic                dn_abort,
  input  logic                irq_in,
  output logic                irq_out,
  input  logic                mmr_req,
  output logic                mmr_ack,
  output logic                rma_flag
);
  logic [1:0] pm_state;
  logic       pm_wr_stb;
  logic [1:0] pm_wr_val;
  logic       abort_evt;

  bpg_cfg_port #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .PM_DW(PM_DW), .CAP_DW(CAP_DW), .STS_DW(STS_DW)
  ) u_cfg (
    .clk(clk), .rst(rst),
    .wr_en(cfg_wr_en), .rd_en(cfg_rd_en), .addr(cfg_addr),
    .be(cfg_be), .wdata(cfg_wdata),
    .pm_state(pm_state), .abort_evt(abort_evt),
    .pm_wr_stb(pm_wr_stb), .pm_wr_val(pm_wr_val),
    .rma_flag(rma_flag), .rdata(cfg_rdata), .rd_valid(cfg_rd_valid)
  );

  bpg_pm_reg u_pm (
    .clk(clk), .rst(rst),
    .wr_stb(pm_wr_stb), .wr_val(pm_wr_val), .pm_state(pm_state)
  );

  bpg_gate u_gate (
    .clk(clk), .rst(rst), .pm_state(pm_state),
    .dn_req(dn_req), .dn_type(dn_type),
    .irq_in(irq_in), .mmr_req(mmr_req),
    .dn_claim(dn_claim), .dn_abort(dn_abort),
    .irq_out(irq_out), .mmr_ack(mmr_ack), .abort_evt(abort_evt)
  );
endmodule

// File: rtl/bpg_chk.sv
module bpg_chk #(
  parameter int         ADDR_W = 6,
  parameter logic [5:0] PM_DW  = 6'h21
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              be0,
  input logic [1:0]        wlo,
  input logic              dn_req,
  input logic [1:0]        dn_type,
  input logic              irq_in,
  input logic              dn_claim,
  input logic              dn_abort,
  input logic              irq_out,
  input logic              mmr_ack,
  input logic              rma_flag,
  input logic [1:0]        pm_state
);
  logic pm_hit;
  assign pm_hit = wr_en && (addr == ADDR_W'(PM_DW));

  AST_CLAIM_ABORT_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(dn_claim && dn_abort)); // R6
  AST_UNSUP_WR_DROPPED: assert property (@(posedge clk) disable iff (rst)
    (pm_hit && be0 && (wlo == 2'b01 || wlo == 2'b10)) |=> $stable(pm_state)); // R3
  AST_NO_BE0_KEEP: assert property (@(posedge clk) disable iff (rst)
    (pm_hit && !be0) |=> $stable(pm_state)); // R4
  AST_D3_ABORT: assert property (@(posedge clk) disable iff (rst)
    (dn_req && pm_state == 2'b11 && dn_type != 2'b10) |=> dn_abort); // R7
  AST_CFG0_CLAIM: assert property (@(posedge clk) disable iff (rst)
    (dn_req && dn_type == 2'b10) |=> dn_claim); // R7
  AST_ABORT_FLAG: assert property (@(posedge clk) disable iff (rst)
    dn_abort |-> rma_flag); // R10
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (rst)
    irq_out |-> ($past(irq_in) && $past(pm_state) == 2'b00)); // R8
  AST_MMR_D0: assert property (@(posedge clk) disable iff (rst)
    mmr_ack |-> ($past(pm_state) == 2'b00)); // R9
endmodule

bind bridge_pm_gate bpg_chk #(.ADDR_W(ADDR_W), .PM_DW(PM_DW)) u_chk (
  .clk(clk), .rst(rst), .wr_en(cfg_wr_en), .addr(cfg_addr),
  .be0(cfg_be[0]), .wlo(cfg_wdata[1:0]),
  .dn_req(dn_req), .dn_type(dn_type), .irq_in(irq_in),
  .dn_claim(dn_claim), .dn_abort(dn_abort), .irq_out(irq_out),
  .mmr_ack(mmr_ack), .rma_flag(rma_flag), .pm_state(pm_state)
);

// File: tb/bridge_pm_gate_tb.sv
module bridge_pm_gate_tb;
  localparam int CLK_NS = 10;
  localparam logic [5:0] PM = 6'h21, CAP = 6'h22, STS = 6'h01;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 0, cfg_rd_en = 0;
  logic [5:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        cfg_rd_valid;
  logic        dn_req = 0;
  logic [1:0]  dn_type = '0;
  logic        dn_claim, dn_abort;
  logic        irq_in = 0, irq_out;
  logic        mmr_req = 0, mmr_ack;
  logic        rma_flag;

  int n_chk = 0, n_fail = 0;
  logic [1:0] e_state = 2'b00;
  logic       e_flag  = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  bridge_pm_gate u_dut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_rd_en(cfg_rd_en),
    .cfg_addr(cfg_addr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .cfg_rd_valid(cfg_rd_valid),
    .dn_req(dn_req), .dn_type(dn_type), .dn_claim(dn_claim), .dn_abort(dn_abort),
    .irq_in(irq_in), .irq_out(irq_out), .mmr_req(mmr_req), .mmr_ack(mmr_ack),
    .rma_flag(rma_flag)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] read_model(input logic [5:0] a);
    if (a == PM)  return 32'h8 | {30'b0, e_state};
    if (a == CAP) return 32'h0000_800D;
    if (a == STS) return e_flag ? 32'h2000_0000 : 32'h0;
    return 32'h0;
  endfunction

  // One clock: drive on the falling edge, compare just after the rising edge.
  task automatic cyc(input string tag, input logic wr, input logic rd,
                     input logic [5:0] a, input logic [3:0] be, input logic [31:0] wd,
                     input logic rq, input logic [1:0] ty, input logic iq, input logic mq);
    logic        x_claim, x_abort, x_irq, x_mmr, nf;
    logic [1:0]  ns;
    logic [31:0] x_rd;
    string       t_gate, t_rd;
    @(negedge clk);
    cfg_wr_en = wr; cfg_rd_en = rd; cfg_addr = a; cfg_be = be; cfg_wdata = wd;
    dn_req = rq; dn_type = ty; irq_in = iq; mmr_req = mq;
    x_claim = rq && (e_state == 2'b00 || ty == 2'b10);
    x_abort = rq && !x_claim;
    x_irq   = iq && e_state == 2'b00;
    x_mmr   = mq && e_state == 2'b00;
    x_rd    = read_model(a);
    nf = e_flag;
    if (x_abort) nf = 1'b1;
    else if (wr && a == STS && be[3] && wd[29]) nf = 1'b0;
    ns = e_state;
    if (wr && a == PM && be[0] && (wd[1:0] == 2'b00 || wd[1:0] == 2'b11)) ns = wd[1:0];
    t_gate = (tag != "") ? tag : ((e_state == 2'b00) ? "R6" : "R7");
    t_rd   = (tag != "") ? tag : (a == PM) ? "R2" : (a == CAP) ? "R11" :
             (a == STS) ? "R10" : "R12";
    @(posedge clk); #1;
    chk(t_gate, {31'b0, dn_claim}, {31'b0, x_claim});
    chk(t_gate, {31'b0, dn_abort}, {31'b0, x_abort});
    chk((tag != "") ? tag : "R8", {31'b0, irq_out}, {31'b0, x_irq});
    chk((tag != "") ? tag : "R9", {31'b0, mmr_ack}, {31'b0, x_mmr});
    chk("R12", {31'b0, cfg_rd_valid}, {31'b0, rd});
    if (rd) chk(t_rd, cfg_rdata, x_rd);
    chk("R10", {31'b0, rma_flag}, {31'b0, nf});
    e_state = ns;
    e_flag  = nf;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_NS * 150000);
    n_fail++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    // R1: reset values of the outputs
    chk("R1", {27'b0, dn_claim, dn_abort, irq_out, mmr_ack, rma_flag}, 32'h0);
    chk("R1", cfg_rdata, 32'h0);
    cyc("R1", 0, 1, PM, 4'h0, 0, 0, 0, 0, 0);
    // R2: enter D3 and read it back
    cyc("R2", 1, 0, PM, 4'h1, 32'h3, 0, 0, 0, 0);
    cyc("R2", 0, 1, PM, 4'h0, 0, 0, 0, 0, 0);
    // R3: unsupported encodings are dropped
    cyc("R3", 1, 0, PM, 4'hF, 32'h1, 0, 0, 0, 0);
    cyc("R3", 1, 1, PM, 4'hF, 32'h2, 0, 0, 0, 0);
    cyc("R3", 0, 1, PM, 4'h0, 0, 0, 0, 0, 0);
    // R4: no byte-0 enable, no change
    cyc("R4", 1, 0, PM, 4'hE, 32'hFFFF_FFFC, 0, 0, 0, 0);
    cyc("R4", 0, 1, PM, 4'h0, 0, 0, 0, 0, 0);
    // R7: each cycle type in D3
    for (int t = 0; t < 4; t++) cyc("R7", 0, 0, 6'h0, 4'h0, 0, 1, 2'(t), 1, 1);
    // R10: clear with a simultaneous abort keeps the flag, then a clean clear
    cyc("R10", 1, 0, STS, 4'h8, 32'h2000_0000, 1, 2'b00, 0, 0);
    cyc("R10", 1, 1, STS, 4'h8, 32'h2000_0000, 0, 2'b00, 0, 0);
    // R5: return to D0 while requesting: old state decides
    cyc("R5", 1, 0, PM, 4'h1, 32'h0, 1, 2'b01, 1, 1);
    cyc("R5", 0, 0, PM, 4'h0, 0, 1, 2'b01, 1, 1);
    // R6: each cycle type in D0
    for (int t = 0; t < 4; t++) cyc("R6", 0, 0, 6'h0, 4'h0, 0, 1, 2'(t), 0, 0);
    // R11: write to the capability dword is ignored
    cyc("R11", 1, 0, CAP, 4'hF, 32'hFFFF_FFFF, 0, 0, 0, 0);
    cyc("R11", 0, 1, CAP, 4'h0, 0, 0, 0, 0, 0);
    // Random traffic
    for (int i = 0; i < 4000; i++) begin
      logic [5:0]  a;
      logic [31:0] wd;
      case ($urandom % 4)
        0: a = STS;
        1: a = PM;
        2: a = CAP;
        default: a = 6'($urandom);
      endcase
      wd = $urandom;
      if ($urandom % 2 == 0) wd[1:0] = 2'($urandom % 4);
      cyc("", ($urandom % 3) == 0, ($urandom % 2) == 0, a, 4'($urandom), wd,
          ($urandom % 2) == 0, 2'($urandom), ($urandom % 2) == 0, ($urandom % 2) == 0);
    end
    finish_run();
  end
endmodule